// File: doc/BRIEF.md
# External Interrupt Edge and Level Controller

This block collects external interrupt pins and turns them into interrupt requests and a wake-up signal for the standby controller. It serves two groups of pins. The first group is a small set of independent edge channels. Each edge channel has a two-bit mode field that selects rising, falling or both edges, or turns detection off. It also has an enable bit and a sticky source flag, and it drives its own request line. The second group is a bank of level-sensitive wake-up pins. They share one request line, and they have an enable register and a flag register, both one byte wide.

Every pin passes through a two-flop synchronizer and then a glitch filter. A new pin level is accepted only after the synchronized value has differed from the accepted level for `FILT_LEN` consecutive clocks. The edge detector and the level detector see only accepted levels. Detection needs nothing but the block clock, so the edge channels keep working in stop mode as long as the standby controller keeps that clock running. The wake-up output is high whenever any request is pending. Software accesses the block through a simple register port with a write strobe and a combinational read.

Top module: `ext_irq_ctrl`

Register map (3-bit address, 8-bit data): 0 = edge mode, with channel i in bits [2i+1:2i] (00 off, 01 rising, 10 falling, 11 both); 1 = edge enable, bit i for channel i; 2 = edge flags; 3 = wake enable, bit k for pin k; 4 = wake flags. Other addresses read as zero.

## Requirements
- R1: After reset, all registers read zero, and `edge_irq_o`, `wake_irq_o` and `wake_o` are low.
- R2: An edge channel in mode 01 sets its flag on an accepted low-to-high transition and ignores high-to-low transitions.
- R3: An edge channel in mode 10 sets its flag on an accepted high-to-low transition and ignores low-to-high transitions.
- R4: Mode 11 sets the flag on either transition. Mode 00 sets it on neither.
- R5: A qualified edge sets the flag even when the channel enable bit is 0. `edge_irq_o[i]` is high exactly when flag i and enable i are both 1.
- R6: Writing a flag register clears each bit written as 0 and keeps each bit written as 1.
- R7: When a flag-setting condition and a clear happen in the same cycle, the flag stays set.
- R8: A pin level that holds for fewer than `FILT_LEN` clocks after synchronization has no effect. A level that holds for exactly `FILT_LEN` clocks is accepted.
- R9: A wake flag bit is set in every cycle where its accepted pin level is low and its enable bit is 1. It is never set while the enable bit is 0.
- R10: `wake_irq_o` is high exactly when some wake pin has both its flag and its enable bit at 1.
- R11: `wake_o` is high when any edge request or the wake request is high, and low otherwise.
- R12: The mode and enable registers read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_pin_i | input | NUM_EDGE | Edge channel pins, idle high |
| wake_pin_i | input | NUM_WAKE | Level wake-up pins, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| edge_irq_o | output | NUM_EDGE | Per-channel edge request |
| wake_irq_o | output | 1 | Shared wake-up request |
| wake_o | output | 1 | Wake signal to the standby controller |

## Verification
The bench builds the block with three edge channels and eight wake pins, which are the full widths of the default register map. It shortens `FILT_LEN` to 4, so that a glitch of one to three clocks and a pulse of exactly four clocks both fit in a short run and the filter boundary can be checked directly. Random steps and glitches on random channels, under random modes and enables, exercise every mode encoding in both edge directions. Directed cases cover a clear that coincides with a held wake level, and the case where an enable is dropped while its flag stays set.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;

    localparam logic [REG_AW-1:0] ADDR_EDGE_MODE = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_EDGE_EN   = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_EDGE_FLAG = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_WAKE_EN   = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_WAKE_FLAG = 3'd4;

endpackage

// File: rtl/eint_pin_filter.sv
module eint_pin_filter #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);
    localparam int CNT_W = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

    typedef struct packed {
        logic [1:0]       sync;
        logic             lvl;
        logic [CNT_W-1:0] cnt;
    } filt_state_t;

    localparam filt_state_t FILT_RST = '{sync: 2'b11, lvl: 1'b1, cnt: '0};

    filt_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], pin_i};
        if (st_q.sync[1] == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.lvl = st_q.sync[1];
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FILT_RST;
        else        st_q <= st_d;
    end

    assign level_o = st_q.lvl;

    // Accepted level changes only to the synchronized value after a full run
    AST_FILT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl != $past(st_q.lvl)) |->
            (st_q.lvl == $past(st_q.sync[1]) && $past(st_q.cnt) == CNT_LAST)); // R8

    AST_FILT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_LAST); // R8

endmodule

// File: rtl/eint_edge_unit.sv
module eint_edge_unit
    import eint_pkg::*;
#(
    parameter int NUM_EDGE = 3,
    parameter int FILT_LEN = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_EDGE-1:0]   pin_i,
    input  logic [2*NUM_EDGE-1:0] mode_i,
    input  logic [NUM_EDGE-1:0]   en_i,
    input  logic [NUM_EDGE-1:0]   clr_i,
    output logic [NUM_EDGE-1:0]   flag_o,
    output logic [NUM_EDGE-1:0]   irq_o
);
    typedef struct packed {
        logic [NUM_EDGE-1:0] prev;
        logic [NUM_EDGE-1:0] flag;
    } edge_state_t;

    localparam edge_state_t EDGE_RST = '{prev: '1, flag: '0};

    logic [NUM_EDGE-1:0] lvl;
    edge_state_t st_d, st_q;

    for (genvar g = 0; g < NUM_EDGE; g++) begin : g_filt
        eint_pin_filter #(.FILT_LEN(FILT_LEN)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[g]),
            .level_o(lvl[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        for (int i = 0; i < NUM_EDGE; i++) begin
            logic       rise, fall, hit;
            edge_mode_e mode;
            mode = edge_mode_e'(mode_i[2*i +: 2]);
            rise = lvl[i] & ~st_q.prev[i];
            fall = ~lvl[i] & st_q.prev[i];
            unique case (mode)
                EDGE_RISE: hit = rise;
                EDGE_FALL: hit = fall;
                EDGE_BOTH: hit = rise | fall;
                default:   hit = 1'b0;
            endcase
            st_d.flag[i] = hit | (st_q.flag[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_RST;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & en_i;

    for (genvar g = 0; g < NUM_EDGE; g++) begin : g_chk
        // A flag only rises after an accepted transition under a live mode
        AST_EDGE_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flag[g] && !$past(st_q.flag[g])) |->
                ($past(mode_i[2*g +: 2]) != 2'b00 && $past(lvl[g]) != $past(st_q.prev[g]))); // R4

        AST_EDGE_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (!st_q.flag[g] && $past(st_q.flag[g])) |-> $past(clr_i[g])); // R6

        AST_EDGE_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flag[g] && !$past(st_q.flag[g]) && $past(mode_i[2*g +: 2]) == 2'b01) |->
                $past(lvl[g])); // R2
    end

endmodule

// File: rtl/eint_wake_unit.sv
module eint_wake_unit #(
    parameter int NUM_WAKE = 8,
    parameter int FILT_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAKE-1:0] pin_i,
    input  logic [NUM_WAKE-1:0] en_i,
    input  logic [NUM_WAKE-1:0] clr_i,
    output logic [NUM_WAKE-1:0] flag_o,
    output logic                irq_o
);
    typedef struct packed {
        logic [NUM_WAKE-1:0] flag;
    } wake_state_t;

    localparam wake_state_t WAKE_RST = '{flag: '0};

    logic [NUM_WAKE-1:0] lvl;
    wake_state_t st_d, st_q;

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_filt
        eint_pin_filter #(.FILT_LEN(FILT_LEN)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_i[g]),
            .level_o(lvl[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.flag = (en_i & ~lvl) | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WAKE_RST;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign irq_o  = |(st_q.flag & en_i);

    for (genvar g = 0; g < NUM_WAKE; g++) begin : g_chk
        AST_WAKE_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.flag[g] && !$past(st_q.flag[g])) |->
                ($past(en_i[g]) && !$past(lvl[g]))); // R9

        AST_WAKE_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(en_i[g]) && !$past(lvl[g])) |-> st_q.flag[g]); // R7
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_EDGE = 3,
    parameter int NUM_WAKE = 8,
    parameter int FILT_LEN = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EDGE-1:0] edge_pin_i,
    input  logic [NUM_WAKE-1:0] wake_pin_i,
    input  logic                reg_we_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [7:0]          reg_wdata_i,
    output logic [7:0]          reg_rdata_o,
    output logic [NUM_EDGE-1:0] edge_irq_o,
    output logic                wake_irq_o,
    output logic                wake_o
);
    localparam int MODE_W = 2 * NUM_EDGE;

    typedef struct packed {
        logic [MODE_W-1:0]   mode;
        logic [NUM_EDGE-1:0] een;
        logic [NUM_WAKE-1:0] wen;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RST = '{mode: '0, een: '0, wen: '0};

    ctrl_state_t st_d, st_q;
    logic [NUM_EDGE-1:0] edge_clr, edge_flag;
    logic [NUM_WAKE-1:0] wake_clr, wake_flag;

    always_comb begin
        st_d     = st_q;
        edge_clr = '0;
        wake_clr = '0;
        if (reg_we_i) begin
            unique case (reg_addr_i)
                ADDR_EDGE_MODE: st_d.mode = reg_wdata_i[MODE_W-1:0];
                ADDR_EDGE_EN:   st_d.een  = reg_wdata_i[NUM_EDGE-1:0];
                ADDR_EDGE_FLAG: edge_clr  = ~reg_wdata_i[NUM_EDGE-1:0];
                ADDR_WAKE_EN:   st_d.wen  = reg_wdata_i[NUM_WAKE-1:0];
                ADDR_WAKE_FLAG: wake_clr  = ~reg_wdata_i[NUM_WAKE-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_RST;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_EDGE_MODE: reg_rdata_o[MODE_W-1:0]   = st_q.mode;
            ADDR_EDGE_EN:   reg_rdata_o[NUM_EDGE-1:0] = st_q.een;
            ADDR_EDGE_FLAG: reg_rdata_o[NUM_EDGE-1:0] = edge_flag;
            ADDR_WAKE_EN:   reg_rdata_o[NUM_WAKE-1:0] = st_q.wen;
            ADDR_WAKE_FLAG: reg_rdata_o[NUM_WAKE-1:0] = wake_flag;
            default: ;
        endcase
    end

    eint_edge_unit #(.NUM_EDGE(NUM_EDGE), .FILT_LEN(FILT_LEN)) edge_u (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (edge_pin_i),
        .mode_i(st_q.mode),
        .en_i  (st_q.een),
        .clr_i (edge_clr),
        .flag_o(edge_flag),
        .irq_o (edge_irq_o)
    );

    eint_wake_unit #(.NUM_WAKE(NUM_WAKE), .FILT_LEN(FILT_LEN)) wake_u (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (wake_pin_i),
        .en_i  (st_q.wen),
        .clr_i (wake_clr),
        .flag_o(wake_flag),
        .irq_o (wake_irq_o)
    );

    assign wake_o = (|edge_irq_o) | wake_irq_o;

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_irq_o & ~st_q.een) == '0); // R5

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(reg_we_i) && $past(reg_addr_i) == ADDR_EDGE_EN) |->
            st_q.een == $past(reg_wdata_i[NUM_EDGE-1:0])); // R12

endmodule

// File: tb/ext_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb_top;
    localparam int NE = 3;
    localparam int NW = 8;
    localparam int FL = 4;
    localparam int SETTLE = 3 * FL + 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] edge_pin = '1;
    logic [NW-1:0] wake_pin = '1;
    logic          we = 1'b0;
    logic [2:0]    addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic [NE-1:0] edge_irq;
    logic          wake_irq, wake_sig;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ext_irq_ctrl #(.NUM_EDGE(NE), .NUM_WAKE(NW), .FILT_LEN(FL)) dut_i (
        .clk(clk), .rst_n(rst_n), .edge_pin_i(edge_pin), .wake_pin_i(wake_pin),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .edge_irq_o(edge_irq), .wake_irq_o(wake_irq), .wake_o(wake_sig)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    function automatic logic exp_hit(input logic [1:0] m, input logic rising);
        return (m == 2'b01 && rising) || (m == 2'b10 && !rising) || (m == 2'b11);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [5:0] mode_m;
        logic [NE-1:0] en_m;
        logic [NE-1:0] cur;
        void'($urandom(32'd20240611));

        wcyc(4);
        rst_n = 1'b1;
        wcyc(2);

        // R1: reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), d);
            chk("R1 reg reset", d, 0);
        end
        chk("R1 edge_irq", edge_irq, 0);
        chk("R1 wake_irq", wake_irq, 0);
        chk("R1 wake_o", wake_sig, 0);

        // R12: readback
        wr(3'd0, 8'h2d); rd(3'd0, d); chk("R12 mode readback", d, 8'h2d);
        wr(3'd1, 8'h05); rd(3'd1, d); chk("R12 edge en readback", d, 8'h05);
        wr(3'd3, 8'ha6); rd(3'd3, d); chk("R12 wake en readback", d, 8'ha6);
        wr(3'd3, 8'h00); wr(3'd1, 8'h00);

        // R8: boundary of the filter, channel 0 in both-edge mode
        wr(3'd0, 8'h03);
        edge_pin[0] = 1'b0; wcyc(FL - 1); edge_pin[0] = 1'b1; wcyc(SETTLE);
        rd(3'd2, d); chk("R8 short pulse rejected", d, 0);
        edge_pin[0] = 1'b0; wcyc(FL); edge_pin[0] = 1'b1; wcyc(SETTLE);
        rd(3'd2, d); chk("R8 exact pulse accepted", d[0], 1);
        wr(3'd2, 8'h00);

        // R5 / R6: set flags on ch0 and ch1 with enables off
        wr(3'd0, 8'h0f);
        edge_pin[1:0] = 2'b00; wcyc(SETTLE);
        rd(3'd2, d); chk("R5 flags set while disabled", d, 8'h03);
        chk("R5 no irq while disabled", edge_irq, 0);
        chk("R11 wake_o low", wake_sig, 0);
        wr(3'd1, 8'h02);
        chk("R5 irq follows enable", edge_irq, 3'b010);
        chk("R11 wake_o from edge", wake_sig, 1);
        wr(3'd2, 8'hfe);
        rd(3'd2, d); chk("R6 write 0 clears, 1 keeps", d, 8'h02);
        wr(3'd2, 8'h00); wr(3'd1, 8'h00);
        edge_pin[1:0] = 2'b11; wcyc(SETTLE);
        wr(3'd2, 8'h00);

        // Random edge stimulus
        cur = edge_pin;
        mode_m = '0;
        for (int it = 0; it < 60; it++) begin
            int ch;
            logic [1:0] m;
            logic glitch;
            logic [NE-1:0] expf;
            ch = int'($urandom % NE);
            m = 2'($urandom);
            mode_m[2*ch +: 2] = m;
            en_m = NE'($urandom);
            wr(3'd0, {2'b00, mode_m});
            wr(3'd1, {5'b0, en_m});
            wr(3'd2, 8'h00);
            glitch = ($urandom % 3) == 0;
            expf = '0;
            if (glitch) begin
                edge_pin[ch] = ~cur[ch];
                wcyc(1 + int'($urandom % (FL - 1)));
                edge_pin[ch] = cur[ch];
                wcyc(SETTLE);
                rd(3'd2, d);
                chk("R8 random glitch ignored", d, 0);
            end else begin
                cur[ch] = ~cur[ch];
                edge_pin[ch] = cur[ch];
                wcyc(SETTLE);
                expf[ch] = exp_hit(m, cur[ch]);
                rd(3'd2, d);
                case (m)
                    2'b01:   chk("R2 rising mode flag", d, {5'b0, expf});
                    2'b10:   chk("R3 falling mode flag", d, {5'b0, expf});
                    default: chk("R4 both/off mode flag", d, {5'b0, expf});
                endcase
                chk("R5 irq is flag and enable", edge_irq, expf & en_m);
            end
        end
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);

        // R9: wake level needs enable
        wake_pin[0] = 1'b0; wcyc(SETTLE);
        rd(3'd4, d); chk("R9 no flag while disabled", d, 0);
        chk("R10 no wake irq", wake_irq, 0);
        wr(3'd3, 8'h01); wcyc(2);
        rd(3'd4, d); chk("R9 flag set low and enabled", d, 8'h01);
        chk("R10 wake irq", wake_irq, 1);
        chk("R11 wake_o from wake", wake_sig, 1);
        // R7: clear while level still held low
        wr(3'd4, 8'h00);
        rd(3'd4, d); chk("R7 held level beats clear", d, 8'h01);
        // R10: drop enable, flag stays, irq drops
        wr(3'd3, 8'h00);
        rd(3'd4, d); chk("R10 flag kept without enable", d, 8'h01);
        chk("R10 irq off without enable", wake_irq, 0);
        chk("R11 wake_o off", wake_sig, 0);
        wake_pin[0] = 1'b1; wcyc(SETTLE);
        wr(3'd4, 8'h00);
        rd(3'd4, d); chk("R6 wake flag cleared", d, 0);
        // R8 on wake pin: short low ignored
        wr(3'd3, 8'h80);
        wake_pin[7] = 1'b0; wcyc(FL - 1); wake_pin[7] = 1'b1; wcyc(SETTLE);
        rd(3'd4, d); chk("R8 short wake glitch ignored", d, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule